// File: doc/BRIEF.md
# Cascadable Two-Layer Alpha Blending Stage

This block is one stage of a layer compositor in a display pixel pipeline. Every clock it takes one pixel from a top layer and one from a bottom layer. Each pixel carries 10-bit red, green and blue channels, an 8-bit alpha and a valid flag. The stage drives one registered pixel toward the next stage up.

Several stages are chained to build a stack of layers. The output of one stage feeds the bottom input of the stage above it. When no bottom pixel is present, the stage uses its own programmed background colour as the bottom layer, at full opacity. A stage mode chooses what the stage does:

- forward the bottom layer;
- forward the top layer as it is;
- forward the top layer made opaque;
- blend the two layers.

An alpha mode chooses where the blend weight comes from. A flag says whether the top colour already carries its alpha.

Configuration is written into a staging copy at any time. The configuration that is in use is loaded from the staging copy only on a frame-start pulse, so a frame never sees a half-applied setting. A value of 255 on any 8-bit weight means unity. Every product of a value and a weight is rounded as (x*w + 127) / 255.

Top module: `layer_blend_stage`

## Requirements
- R1: A configuration write (cfg_we high) only updates the staging copy, and pixels keep using the previous configuration. A frame_start pulse makes the staged values active for pixels presented in later cycles. A write in the same cycle as frame_start is included in that update.
- R2: Outputs are registered. A pixel presented before a rising edge appears on the outputs after that edge, and the outputs do not change between edges.
- R3: Stage mode 0 (bypass) forwards the bottom pixel's colour and alpha unchanged, with out_valid high, when bot_valid is high.
- R4: Stage mode 1 (passthrough) forwards the top pixel's colour and alpha unchanged, with out_valid high, when top_valid is high.
- R5: Stage mode 2 (top only) forwards the top pixel's colour with out_a forced to 255 when top_valid is high.
- R6: Stage mode 3 (blend), with premultiply off, gives each channel as (top*a + bot*(255-a) + 127)/255. Here bot is the bottom pixel when bot_valid is high, otherwise the background colour.
- R7: With premultiply on, the blended channel is top + (bot*(255-a) + 127)/255, saturated at 1023.
- R8: The weight a follows alpha mode 0 = top_a, 1 = (top_a*global_gain + 127)/255, 2 = global_alpha (pixel alpha ignored). The value 3 behaves as 0.
- R9: In blend mode, with bot_valid low and overlap-only off, the top pixel is blended over the background colour, and the background counts as alpha 255.
- R10: In any mode, when the selected layer or layers are absent, out_valid is low, out_a is 255 and the colour is the active background colour. In blend mode this happens only when neither valid is high.
- R11: With overlap-only on in blend mode, a top pixel without a bottom pixel is forwarded unchanged with out_valid high. A bottom pixel alone is forwarded unchanged in blend mode whatever the overlap setting.
- R12: After reset all outputs are zero. The active configuration is bypass mode, alpha mode 0, premultiply off, overlap-only off, global alpha and gain 255, and a black background.
- R13: In blend mode, with the top pixel present and blending, out_a = a + (bot_alpha*(255-a) + 127)/255. Here bot_alpha is bot_a, or 255 for the background.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Frame boundary pulse; loads the staged configuration |
| cfg_we | input | 1 | Write strobe for the staging copy |
| cfg_mode | input | 2 | Stage mode: 0 bypass, 1 passthrough, 2 top only, 3 blend |
| cfg_alpha_mode | input | 2 | Alpha source: 0 pixel, 1 pixel times gain, 2 global |
| cfg_premult | input | 1 | Top colour already scaled by alpha |
| cfg_overlap_only | input | 1 | Blend only where both layers are present |
| cfg_global_alpha | input | 8 | Plane-wide alpha |
| cfg_global_gain | input | 8 | Gain applied to the pixel alpha |
| cfg_bg_r | input | 10 | Background red |
| cfg_bg_g | input | 10 | Background green |
| cfg_bg_b | input | 10 | Background blue |
| top_valid | input | 1 | Top pixel present |
| top_r | input | 10 | Top red |
| top_g | input | 10 | Top green |
| top_b | input | 10 | Top blue |
| top_a | input | 8 | Top alpha |
| bot_valid | input | 1 | Bottom pixel present |
| bot_r | input | 10 | Bottom red |
| bot_g | input | 10 | Bottom green |
| bot_b | input | 10 | Bottom blue |
| bot_a | input | 8 | Bottom alpha |
| out_valid | output | 1 | Output pixel covered by a layer |
| out_r | output | 10 | Output red |
| out_g | output | 10 | Output green |
| out_b | output | 10 | Output blue |
| out_a | output | 8 | Output alpha |

## Verification
The hardest situation to reach from the ports is a configuration that is staged but not yet active. The outputs alone give no sign that a write has landed, so the stimulus writes a new mode and checks that pixels still follow the old one. It then pulses frame_start and checks that the new mode takes over. A further case writes and pulses in the same cycle. Premultiplied saturation is also hard to reach, because it needs full-scale top and bottom channels under a near-zero weight. The sweep therefore includes one pixel set with every channel at 1023 and alpha 1, and runs it under all alpha modes and both overlap settings.

// File: rtl/layer_blend_stage.sv
module layer_blend_stage #(
  parameter int CW = 10,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_start,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_mode,
  input  logic [1:0]    cfg_alpha_mode,
  input  logic          cfg_premult,
  input  logic          cfg_overlap_only,
  input  logic [AW-1:0] cfg_global_alpha,
  input  logic [AW-1:0] cfg_global_gain,
  input  logic [CW-1:0] cfg_bg_r,
  input  logic [CW-1:0] cfg_bg_g,
  input  logic [CW-1:0] cfg_bg_b,
  input  logic          top_valid,
  input  logic [CW-1:0] top_r,
  input  logic [CW-1:0] top_g,
  input  logic [CW-1:0] top_b,
  input  logic [AW-1:0] top_a,
  input  logic          bot_valid,
  input  logic [CW-1:0] bot_r,
  input  logic [CW-1:0] bot_g,
  input  logic [CW-1:0] bot_b,
  input  logic [AW-1:0] bot_a,
  output logic          out_valid,
  output logic [CW-1:0] out_r,
  output logic [CW-1:0] out_g,
  output logic [CW-1:0] out_b,
  output logic [AW-1:0] out_a
);
  localparam int WW   = CW + AW + 1;
  localparam int CFGW = 6 + 2*AW + 3*CW;
  localparam logic [AW-1:0] AONE = '1;
  localparam logic [WW-1:0] DIV  = WW'((1 << AW) - 1);
  localparam logic [WW-1:0] HALF = WW'(((1 << AW) - 1) / 2);
  localparam logic [WW-1:0] CLIM = WW'((1 << CW) - 1);
  localparam logic [CFGW-1:0] CFG_RST = {2'd0, 2'd0, 1'b0, 1'b0, AONE, AONE, {(3*CW){1'b0}}};

  function automatic logic [WW-1:0] rnd(input logic [WW-1:0] p);
    rnd = (p + HALF) / DIV;
  endfunction

  logic [CFGW-1:0] stg_cfg, act_cfg, wr_cfg;
  logic [1:0]      act_mode, act_amode;
  logic            act_pm, act_ovl;
  logic [AW-1:0]   act_ga, act_gg;
  logic [CW-1:0]   act_bg_r, act_bg_g, act_bg_b;

  assign wr_cfg = {cfg_mode, cfg_alpha_mode, cfg_premult, cfg_overlap_only,
                   cfg_global_alpha, cfg_global_gain, cfg_bg_r, cfg_bg_g, cfg_bg_b};
  assign {act_mode, act_amode, act_pm, act_ovl, act_ga, act_gg,
          act_bg_r, act_bg_g, act_bg_b} = act_cfg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg_cfg <= CFG_RST;
      act_cfg <= CFG_RST;
    end else begin
      if (cfg_we)      stg_cfg <= wr_cfg;
      if (frame_start) act_cfg <= cfg_we ? wr_cfg : stg_cfg;
    end
  end

  logic [WW-1:0] gained;
  logic [AW-1:0] a_w, inv_w, beff_a;
  assign gained = rnd(WW'(top_a) * WW'(act_gg));
  assign a_w    = (act_amode == 2'd2) ? act_ga :
                  (act_amode == 2'd1) ? gained[AW-1:0] : top_a;
  assign inv_w  = AONE - a_w;
  assign beff_a = bot_valid ? bot_a : AONE;

  logic [WW-1:0] blend_a_w;
  assign blend_a_w = WW'(a_w) + rnd(WW'(beff_a) * WW'(inv_w));

  logic [CW-1:0] top_c [3];
  logic [CW-1:0] bot_c [3];
  logic [CW-1:0] bg_c  [3];
  logic [CW-1:0] mix_c [3];
  logic [CW-1:0] nxt_c [3];
  logic [CW-1:0] out_c [3];

  assign top_c = '{top_r, top_g, top_b};
  assign bot_c = '{bot_r, bot_g, bot_b};
  assign bg_c  = '{act_bg_r, act_bg_g, act_bg_b};

  for (genvar ch = 0; ch < 3; ch++) begin : g_chan
    logic [CW-1:0] beff;
    logic [WW-1:0] bterm, straight, premul;
    assign beff     = bot_valid ? bot_c[ch] : bg_c[ch];
    assign bterm    = WW'(beff) * WW'(inv_w);
    assign straight = rnd(WW'(top_c[ch]) * WW'(a_w) + bterm);
    assign premul   = WW'(top_c[ch]) + rnd(bterm);
    assign mix_c[ch] = act_pm ? ((premul > CLIM) ? CLIM[CW-1:0] : premul[CW-1:0])
                              : straight[CW-1:0];
  end

  logic          nxt_v;
  logic [AW-1:0] nxt_a;

  always_comb begin
    nxt_v = 1'b0;
    nxt_c = bg_c;
    nxt_a = AONE;
    case (act_mode)
      2'd0: if (bot_valid) begin
        nxt_v = 1'b1; nxt_c = bot_c; nxt_a = bot_a;
      end
      2'd1: if (top_valid) begin
        nxt_v = 1'b1; nxt_c = top_c; nxt_a = top_a;
      end
      2'd2: if (top_valid) begin
        nxt_v = 1'b1; nxt_c = top_c; nxt_a = AONE;
      end
      default: begin
        if (top_valid && (bot_valid || !act_ovl)) begin
          nxt_v = 1'b1; nxt_c = mix_c; nxt_a = blend_a_w[AW-1:0];
        end else if (top_valid) begin
          nxt_v = 1'b1; nxt_c = top_c; nxt_a = top_a;
        end else if (bot_valid) begin
          nxt_v = 1'b1; nxt_c = bot_c; nxt_a = bot_a;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_c     <= '{default: '0};
      out_a     <= '0;
    end else begin
      out_valid <= nxt_v;
      out_c     <= nxt_c;
      out_a     <= nxt_a;
    end
  end

  assign out_r = out_c[0];
  assign out_g = out_c[1];
  assign out_b = out_c[2];

  a_r1_active_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(act_cfg));

  a_r3_bypass_forwards: assert property (@(posedge clk) disable iff (!rst_n)
    (act_mode == 2'd0 && bot_valid) |=>
      (out_valid && out_r == $past(bot_r) && out_b == $past(bot_b) && out_a == $past(bot_a)));

  a_r5_top_only_opaque: assert property (@(posedge clk) disable iff (!rst_n)
    (act_mode == 2'd2 && top_valid) |=> (out_valid && out_a == AONE && out_g == $past(top_g)));

  a_r10_empty_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (!top_valid && !bot_valid) |=> (!out_valid && out_a == AONE && out_r == $past(act_bg_r)));

  a_r13_alpha_not_below_weight: assert property (@(posedge clk) disable iff (!rst_n)
    (act_mode == 2'd3 && top_valid && bot_valid) |=> (out_a >= $past(a_w)));
endmodule

// File: tb/layer_blend_stage_bench.sv
module layer_blend_stage_bench;
  localparam int CW = 10;
  localparam int AW = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, frame_start, cfg_we, cfg_premult, cfg_overlap_only;
  logic [1:0] cfg_mode, cfg_alpha_mode;
  logic [AW-1:0] cfg_global_alpha, cfg_global_gain;
  logic [CW-1:0] cfg_bg_r, cfg_bg_g, cfg_bg_b;
  logic top_valid, bot_valid;
  logic [CW-1:0] top_r, top_g, top_b, bot_r, bot_g, bot_b;
  logic [AW-1:0] top_a, bot_a;
  logic out_valid;
  logic [CW-1:0] out_r, out_g, out_b;
  logic [AW-1:0] out_a;

  layer_blend_stage #(.CW(CW), .AW(AW)) u_layer_blend_stage (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .cfg_we(cfg_we),
    .cfg_mode(cfg_mode), .cfg_alpha_mode(cfg_alpha_mode), .cfg_premult(cfg_premult),
    .cfg_overlap_only(cfg_overlap_only), .cfg_global_alpha(cfg_global_alpha),
    .cfg_global_gain(cfg_global_gain), .cfg_bg_r(cfg_bg_r), .cfg_bg_g(cfg_bg_g),
    .cfg_bg_b(cfg_bg_b), .top_valid(top_valid), .top_r(top_r), .top_g(top_g),
    .top_b(top_b), .top_a(top_a), .bot_valid(bot_valid), .bot_r(bot_r), .bot_g(bot_g),
    .bot_b(bot_b), .bot_a(bot_a), .out_valid(out_valid), .out_r(out_r), .out_g(out_g),
    .out_b(out_b), .out_a(out_a));

  int n_cmp = 0, n_bad = 0;
  int p_mode, p_am, p_pm, p_ov, p_ga, p_gg, p_bg[3];
  int m_mode, m_am, m_pm, m_ov, m_ga, m_gg, m_bg[3];
  int e_v, e_a, e_c[3];
  string e_tag, e_atag;

  function automatic int rnd(int p);
    return (p + 127) / 255;
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic model();
    int tc[3], bc[3], a, inv, bea;
    tc = '{int'(top_r), int'(top_g), int'(top_b)};
    bc = '{int'(bot_r), int'(bot_g), int'(bot_b)};
    e_v = 0; e_a = 255; e_c = m_bg; e_tag = "R10";
    a = (m_am == 2) ? m_ga : (m_am == 1) ? rnd(int'(top_a) * m_gg) : int'(top_a);
    inv = 255 - a;
    bea = bot_valid ? int'(bot_a) : 255;
    case (m_mode)
      0: if (bot_valid) begin e_v = 1; e_c = bc; e_a = int'(bot_a); e_tag = "R3"; end
      1: if (top_valid) begin e_v = 1; e_c = tc; e_a = int'(top_a); e_tag = "R4"; end
      2: if (top_valid) begin e_v = 1; e_c = tc; e_a = 255; e_tag = "R5"; end
      default: begin
        if (top_valid && (bot_valid || m_ov == 0)) begin
          e_v = 1;
          for (int ch = 0; ch < 3; ch++) begin
            int be;
            be = bot_valid ? bc[ch] : m_bg[ch];
            if (m_pm != 0) begin
              e_c[ch] = tc[ch] + rnd(be * inv);
              if (e_c[ch] > 1023) e_c[ch] = 1023;
            end else
              e_c[ch] = rnd(tc[ch] * a + be * inv);
          end
          e_a = a + rnd(bea * inv);
          e_tag = !bot_valid ? "R9" : (m_am != 0) ? "R8" : (m_pm != 0) ? "R7" : "R6";
        end else if (top_valid) begin
          e_v = 1; e_c = tc; e_a = int'(top_a); e_tag = "R11";
        end else if (bot_valid) begin
          e_v = 1; e_c = bc; e_a = int'(bot_a); e_tag = "R11";
        end
      end
    endcase
    e_atag = (m_mode == 3 && top_valid && (bot_valid || m_ov == 0)) ? "R13" : e_tag;
  endtask

  task automatic compare_out();
    check(e_tag, "valid", int'(out_valid), e_v);
    check(e_tag, "red", int'(out_r), e_c[0]);
    check(e_tag, "green", int'(out_g), e_c[1]);
    check(e_tag, "blue", int'(out_b), e_c[2]);
    check(e_atag, "alpha", int'(out_a), e_a);
  endtask

  task automatic step(bit tv, int tr, int tg, int tb, int ta, bit bv, int br, int bgv, int bb, int ba);
    top_valid = tv; top_r = CW'(tr); top_g = CW'(tg); top_b = CW'(tb); top_a = AW'(ta);
    bot_valid = bv; bot_r = CW'(br); bot_g = CW'(bgv); bot_b = CW'(bb); bot_a = AW'(ba);
    model();
    @(negedge clk);
    compare_out();
  endtask

  task automatic write_cfg(int mode, int am, int pm, int ov, int ga, int gg, int r, int g, int b, bit pulse);
    top_valid = 0; bot_valid = 0;
    cfg_mode = 2'(mode); cfg_alpha_mode = 2'(am); cfg_premult = pm[0]; cfg_overlap_only = ov[0];
    cfg_global_alpha = AW'(ga); cfg_global_gain = AW'(gg);
    cfg_bg_r = CW'(r); cfg_bg_g = CW'(g); cfg_bg_b = CW'(b);
    cfg_we = 1; frame_start = pulse;
    p_mode = mode; p_am = am; p_pm = pm; p_ov = ov; p_ga = ga; p_gg = gg; p_bg = '{r, g, b};
    @(negedge clk);
    cfg_we = 0; frame_start = 0;
    if (pulse) begin
      m_mode = p_mode; m_am = p_am; m_pm = p_pm; m_ov = p_ov; m_ga = p_ga; m_gg = p_gg; m_bg = p_bg;
    end
  endtask

  task automatic frame_pulse();
    top_valid = 0; bot_valid = 0;
    frame_start = 1;
    @(negedge clk);
    frame_start = 0;
    m_mode = p_mode; m_am = p_am; m_pm = p_pm; m_ov = p_ov; m_ga = p_ga; m_gg = p_gg; m_bg = p_bg;
  endtask

  function automatic int alist(int k);
    case (k)
      0: return 0;   1: return 255; 2: return 1;   3: return 128;
      4: return 254; 5: return 64;  6: return 200; default: return 127;
    endcase
  endfunction

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0; frame_start = 0; cfg_we = 0;
    cfg_mode = 0; cfg_alpha_mode = 0; cfg_premult = 0; cfg_overlap_only = 0;
    cfg_global_alpha = 0; cfg_global_gain = 0; cfg_bg_r = 0; cfg_bg_g = 0; cfg_bg_b = 0;
    top_valid = 0; bot_valid = 0; top_r = 0; top_g = 0; top_b = 0; top_a = 0;
    bot_r = 0; bot_g = 0; bot_b = 0; bot_a = 0;
    m_mode = 0; m_am = 0; m_pm = 0; m_ov = 0; m_ga = 255; m_gg = 255; m_bg = '{0, 0, 0};
    p_mode = 0; p_am = 0; p_pm = 0; p_ov = 0; p_ga = 255; p_gg = 255; p_bg = '{0, 0, 0};
    repeat (3) @(negedge clk);
    // R12: outputs cleared by reset
    check("R12", "valid", int'(out_valid), 0);
    check("R12", "red", int'(out_r), 0);
    check("R12", "alpha", int'(out_a), 0);
    rst_n = 1;
    // R12: default active configuration is bypass
    step(1, 5, 6, 7, 8, 1, 300, 400, 500, 99);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);

    for (int cfg = 0; cfg < 64; cfg++) begin
      write_cfg(cfg % 4, (cfg / 4) % 4, (cfg / 16) % 2, (cfg / 32) % 2,
                (cfg * 53) % 256, 255 - (cfg * 29) % 256,
                (cfg * 17) % 1024, (cfg * 31 + 3) % 1024, 1023 - cfg * 7, 0);
      frame_pulse();
      for (int vv = 0; vv < 4; vv++)
        for (int k = 0; k < 8; k++) begin
          if (k == 2)
            step(vv[0], 1023, 1023, 1023, alist(k), vv[1], 1023, 1023, 1023, 1023);
          else
            step(vv[0], (k * 389 + 11) % 1024, (k * 211 + 700) % 1024, (k * 97) % 1024, alist(k),
                 vv[1], (k * 151 + 40) % 1024, (k * 613) % 1024, 1000 - k * 9, alist(7 - k));
        end
    end

    // R1: staged write is not visible until frame_start
    write_cfg(0, 0, 0, 0, 255, 255, 0, 0, 0, 1);
    write_cfg(2, 0, 0, 0, 255, 255, 0, 0, 0, 0);
    step(1, 10, 20, 30, 40, 1, 111, 222, 333, 77);
    e_tag = "R1";
    check("R1", "staged mode hidden", int'(out_r), 111);
    frame_pulse();
    step(1, 10, 20, 30, 40, 1, 111, 222, 333, 77);
    check("R1", "mode after pulse alpha", int'(out_a), 255);
    // R1: write coinciding with frame_start takes effect
    write_cfg(1, 0, 0, 0, 255, 255, 0, 0, 0, 1);
    step(1, 10, 20, 30, 40, 1, 111, 222, 333, 77);
    check("R1", "same-cycle write alpha", int'(out_a), 40);

    // R2: output holds between edges, changes after one edge
    step(1, 900, 901, 902, 33, 0, 0, 0, 0, 0);
    top_valid = 1; top_r = 5; top_a = 6;
    #2;
    check("R2", "held red", int'(out_r), 900);
    check("R2", "held alpha", int'(out_a), 33);
    @(negedge clk);
    check("R2", "updated red", int'(out_r), 5);
    check("R2", "updated alpha", int'(out_a), 6);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule